// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is the management-station end of a two-wire PHY management link. A host writes one pre-formatted 32-bit frame word into a command register. The word holds the start, opcode, PHY address, register address, turnaround and write-data fields. The controller sends a preamble of ones on the data line, then shifts the word out MSB first against a management clock that it generates itself.

For a read, the controller lets go of the data line from the turnaround onward and samples the 16 data bits that the PHY returns. It then places them in the low half of the data register. The end of every frame sets a sticky event bit. The host polls that bit and clears it by writing a one to it. A busy flag in a status register shows that a frame is in flight.

The management clock rate comes from a speed register. Its divider field sits one bit above the LSB. Each half period of the clock lasts as many system clocks as the field value, so the clock frequency is the system clock divided by twice the field. Software normally programs the field as the rounded-up quotient of the system clock over 5 MHz, which keeps the management clock at or below 2.5 MHz.

Top module: `mdio_station`

## Requirements
- R1: After reset, all four registers read zero, `mdc` is low and `mdio_oe` is low. A register read returns the register chosen by `reg_sel` one clock after the select is applied. The selects are 0 = data/command, 1 = event, 2 = speed and 3 = status.
- R2: The speed register keeps its divider field S in bits DIV_W:1. While a frame runs, `mdc` stays high for exactly S system clocks and low for S system clocks, and S = 0 acts as 1. `mdc` is low whenever no frame is in progress.
- R3: A write of the command word to select 0 while idle starts a frame. The frame is PRE_BITS (32) ones followed by the 32-bit word, MSB first, for 64 `mdc` periods in total. After a write frame, the data register reads back the command word.
- R4: `mdio_o` changes only in the cycle in which `mdc` falls, for as long as the output stays enabled. Input data is sampled as `mdc` rises.
- R5: A word with bits 29:28 = 2'b10 is a read (for example 0x60020000 with PHY address in bits 27:23 and register in 22:18). The controller drives the frame up to bit 17 of the word. It then releases `mdio_oe` for the turnaround and data bits, and the 16 sampled bits replace bits 15:0 of the data register. Bits 31:16 keep the command value.
- R6: A read to which no PHY answers returns 0xFFFF in bits 15:0, because the idle line is pulled high.
- R7: When a frame ends, event bit 23 becomes 1 and stays 1 until the host writes a word with bit 23 set to select 1. A write to select 1 with bit 23 clear has no effect.
- R8: Status bit 0 is 1 while a frame is in progress. A command write during a frame is ignored: the frame on the line and the final data register belong to the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select for reads and writes |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data value seen at the pad |

## Verification
The assertions assume that `mdio_i` reflects the pad: it reads the controller's own value while `mdio_oe` is high, and otherwise it reads the PHY or the pull-up. They also assume that the host issues a clear of the event bit only through select 1. The bench resolves the pad from `mdio_oe`, a PHY model and a pull-up. The PHY model drives the line only after the controller has released it, beginning at the second turnaround bit. A separate monitor flags any cycle in which both sides drive the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W   = 32;
  localparam int RDAT_W  = 16;
  localparam int EVT_BIT = 23;
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam int TA_HI   = 17;
  localparam logic [1:0] SEL_DATA   = 2'd0;
  localparam logic [1:0] SEL_EVENT  = 2'd1;
  localparam logic [1:0] SEL_SPEED  = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;
  localparam logic [1:0] OP_READ    = 2'b10;
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_eff;
  logic             at_end;

  assign half_eff  = (half == '0) ? DIV_W'(1) : half;
  assign at_end    = en && (cnt == half_eff - DIV_W'(1));
  assign rise_tick = at_end && !mdc;
  assign fall_tick = at_end && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!mdc || en)); // R2
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              finish,
  output logic [RDAT_W-1:0] rd_bits
);
  localparam int TOT     = PRE_BITS + CMD_W;
  localparam int IDX_W   = $clog2(TOT);
  localparam int REL_IDX = PRE_BITS + (CMD_W - 1 - TA_HI);
  localparam int SMP_IDX = PRE_BITS + (CMD_W - RDAT_W);

  logic [TOT-1:0]   sh;
  logic [IDX_W-1:0] idx;
  logic             is_rd;
  int               nxt;

  assign nxt = int'(idx) + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      finish  <= 1'b0;
      rd_bits <= '0;
    end else begin
      finish <= 1'b0;
      if (start && !busy) begin
        sh      <= {{PRE_BITS{1'b1}}, cmd};
        idx     <= '0;
        is_rd   <= (cmd[OP_HI:OP_LO] == OP_READ);
        busy    <= 1'b1;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
        rd_bits <= '0;
      end else if (busy) begin
        if (rise_tick && is_rd && int'(idx) >= SMP_IDX)
          rd_bits <= {rd_bits[RDAT_W-2:0], mdio_i};
        if (fall_tick) begin
          if (int'(idx) == TOT - 1) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            finish  <= 1'b1;
          end else begin
            idx     <= idx + IDX_W'(1);
            sh      <= {sh[TOT-2:0], 1'b0};
            mdio_o  <= sh[TOT-2];
            mdio_oe <= !(is_rd && nxt >= REL_IDX);
          end
        end
      end
    end
  end

  AST_FINISH_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    finish |-> (!busy && $past(busy))); // R3
endmodule

// File: rtl/mdio_station.sv
module mdio_station
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [CMD_W-1:0]  data_q;
  logic              evt_q;
  logic [DIV_W-1:0]  speed_q;
  logic              busy, finish, start, rise_tick, fall_tick, clr_evt;
  logic [RDAT_W-1:0] rd_bits;

  assign start   = reg_wr && (reg_sel == SEL_DATA) && !busy;
  assign clr_evt = reg_wr && (reg_sel == SEL_EVENT) && reg_wdata[EVT_BIT];

  mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(busy), .half(speed_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame #(.PRE_BITS(PRE_BITS)) u_frame (
    .clk(clk), .rst(rst), .start(start), .cmd(reg_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .finish(finish), .rd_bits(rd_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      evt_q     <= 1'b0;
      speed_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (start)
        data_q <= reg_wdata;
      else if (finish && data_q[OP_HI:OP_LO] == OP_READ)
        data_q[RDAT_W-1:0] <= rd_bits;
      if (finish)
        evt_q <= 1'b1;
      else if (clr_evt)
        evt_q <= 1'b0;
      if (reg_wr && reg_sel == SEL_SPEED)
        speed_q <= reg_wdata[DIV_W:1];
      case (reg_sel)
        SEL_DATA:  reg_rdata <= data_q;
        SEL_EVENT: reg_rdata <= 32'(evt_q) << EVT_BIT;
        SEL_SPEED: reg_rdata <= 32'(speed_q) << 1;
        default:   reg_rdata <= 32'(busy);
      endcase
    end
  end

  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc))); // R4
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !clr_evt) |=> evt_q); // R7
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R1
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> $stable(data_q)); // R8
endmodule

// File: tb/tb_mdio_station.sv
module tb_mdio_station;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_in;

  int errors = 0;
  int checks = 0;

  // PHY model state
  logic        phy_en = 1'b0, phy_bit = 1'b1, phy_drv = 1'b0, phy_present = 1'b0;
  logic [4:0]  phy_addr = 5'd5;
  logic [15:0] phy_val = '0;
  logic [63:0] cap = '0;
  int          rises = 0;

  // port monitors
  int  hi_run = 0, last_hi = 0, edge_viol = 0, contention = 0;
  logic prev_o = 1'b1, prev_oe = 1'b0, prev_mdc = 1'b0;

  always #10 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_station dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
  );

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_in};
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises == 47)
      phy_drv = phy_present && (cap[12:11] == 2'b10) && (cap[10:6] == phy_addr);
    if (phy_drv && rises >= 47 && rises <= 63) begin
      phy_en  = 1'b1;
      phy_bit = (rises == 47) ? 1'b0 : phy_val[63 - rises];
    end else begin
      phy_en  = 1'b0;
      phy_bit = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (mdc) hi_run++;
    else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    if (mdio_oe && prev_oe && mdio_o != prev_o && !(prev_mdc && !mdc)) edge_viol++;
    if (mdio_oe && phy_en) contention++;
    prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc = mdc;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    st = 32'd1;
    for (int i = 0; i < 2000 && st[0]; i++) reg_read(2'd3, st);
  endtask

  task automatic frame_prep();
    @(negedge clk);
    rises = 0; phy_drv = 1'b0; cap = '0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), v);
      check("R1 reg after reset", 64'(v), 64'd0);
    end
    check("R1 mdc/oe idle", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic test_write_frame();
    logic [31:0] cmd, v;
    cmd = 32'h5002_0000 | (32'd5 << 23) | (32'h04 << 18) | 32'hBEEF;
    reg_write(2'd2, 32'd3 << 1);
    reg_read(2'd2, v);
    check("R2 speed readback", 64'(v), 64'd6);
    frame_prep();
    reg_write(2'd0, cmd);
    reg_read(2'd3, v);
    check("R8 busy during frame", 64'(v[0]), 64'd1);
    wait_idle();
    check("R3 frame bits", cap, {32'hFFFF_FFFF, cmd});
    check("R3 mdc periods", 64'(rises), 64'd64);
    check("R2 half period S=3", 64'(last_hi), 64'd3);
    check("R2 mdc idle low", 64'(mdc), 64'd0);
    reg_read(2'd0, v);
    check("R3 data holds command", 64'(v), 64'(cmd));
    reg_read(2'd1, v);
    check("R7 event set", 64'(v), 64'h0080_0000);
  endtask

  task automatic test_event_clear();
    logic [31:0] v;
    reg_write(2'd1, 32'hFF7F_FFFF);
    reg_read(2'd1, v);
    check("R7 write without bit23 ignored", 64'(v), 64'h0080_0000);
    reg_write(2'd1, 32'h0080_0000);
    reg_read(2'd1, v);
    check("R7 W1C clears", 64'(v), 64'd0);
  endtask

  task automatic test_read(input logic [4:0] addr, input logic [15:0] val,
                           input logic [15:0] exp, input string req);
    logic [31:0] cmd, v;
    cmd = 32'h6002_0000 | (32'(addr) << 23) | (32'd2 << 18);
    phy_present = 1'b1; phy_val = val;
    frame_prep();
    reg_write(2'd0, cmd);
    wait_idle();
    reg_read(2'd0, v);
    check(req, 64'(v), 64'({cmd[31:16], exp}));
    check("R5 driven head of read frame", 64'(cap[63:18]), 64'({32'hFFFF_FFFF, cmd[31:18]}));
    reg_write(2'd1, 32'h0080_0000);
  endtask

  task automatic test_busy_ignore();
    logic [31:0] a, b, v;
    a = 32'h5002_0000 | (32'd1 << 23) | (32'd7 << 18) | 32'h1357;
    b = 32'h5002_0000 | (32'd2 << 23) | (32'd9 << 18) | 32'hA5A5;
    frame_prep();
    reg_write(2'd0, a);
    reg_write(2'd0, b);
    wait_idle();
    check("R8 frame from first command", cap, {32'hFFFF_FFFF, a});
    reg_read(2'd0, v);
    check("R8 data from first command", 64'(v), 64'(a));
    reg_write(2'd1, 32'h0080_0000);
  endtask

  task automatic test_zero_speed();
    logic [31:0] v;
    reg_write(2'd2, 32'd0);
    frame_prep();
    reg_write(2'd0, 32'h5002_0000 | 32'h00FF);
    wait_idle();
    check("R2 S=0 acts as 1", 64'(last_hi), 64'd1);
    check("R3 frame at S=0", cap, {32'hFFFF_FFFF, 32'h5002_00FF});
    reg_read(2'd1, v);
    check("R7 event after fast frame", 64'(v), 64'h0080_0000);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_write_frame();
    test_event_clear();
    reg_write(2'd2, 32'd2 << 1);
    test_read(5'd5, 16'h1234, 16'h1234, "R5 read data captured");
    test_read(5'd9, 16'h1234, 16'hFFFF, "R6 absent PHY reads FFFF");
    test_busy_ignore();
    test_zero_speed();
    check("R4 output changes only on mdc fall", 64'(edge_viol), 64'd0);
    check("R5 no drive contention", 64'(contention), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule